// File: doc/BRIEF.md
# I2C SCL Clock Divider

This block derives the bit timing of an I2C master from the system clock. A 7-bit divisor holds a linear factor M and an exponent N. From them a prescaler makes a one-cycle sample strobe. A ten-step slot sequencer advances once per strobe. The first half of the sequence pulls SCL low and the second half releases it, so one SCL period spans ten strobes. The byte engine uses the strobe and the slot index to place its SDA changes and its samples.

A mode input picks the exponent convention. In the default convention the prescaler spans (M+1)·2^(N+1) system clocks, and in the alternate one it spans (M+1)·2^N. SCL frequency is therefore the system clock divided by ten times that span. Software chooses M and N (typically for a 100 kHz bus) and writes them through a load strobe. Each write restarts the timing. In the released half, a target that holds SCL low stretches the clock: the strobe and the slot stop until the line is seen high.

Top module: `scl_clkgen`

## Requirements
- R1: While reset is asserted and right after it, `tick` is 0, `slot` is 0 and `scl_pull_low` is 1. The divisor resets to M=0, N=0, which in the default convention gives a strobe every 2 cycles.
- R2: `cfg_div[2:0]` is N and `cfg_div[6:3]` is M. With `exp_sel`=0 the strobe repeats every (M+1)·2^(N+1) cycles.
- R3: With `exp_sel`=1 the strobe repeats every (M+1)·2^N cycles. M=0, N=0 gives a strobe in every cycle.
- R4: `slot` counts 0 to 9, one step per strobe, and wraps from 9 to 0. `scl_pull_low` is 1 while `slot` is 0 to 4 and 0 while `slot` is 5 to 9.
- R5: While `slot` is 5 to 9 and `scl_in` is 0, `tick` stays 0, `slot` holds, and the prescaler is cleared. After `scl_in` returns high, the next strobe comes L-1 cycles after the first cycle in which it is seen high, where L is the span from R2/R3.
- R6: A `cfg_we` pulse loads the divisor and restarts the prescaler and the slot sequence. In the cycle after the loading edge `slot` is 0, and the first strobe appears L-1 cycles after that edge.
- R7: While `slot` is 0 to 4, `scl_in` has no effect: strobes and slot steps continue with SCL held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Load strobe for the divisor; restarts the timing |
| cfg_div | input | 7 | Divisor value: [6:3] M, [2:0] N |
| exp_sel | input | 1 | 0: power term 2^(N+1); 1: power term 2^N |
| scl_in | input | 1 | Synchronized level of the SCL line |
| tick | output | 1 | One-cycle sample strobe |
| slot | output | 4 | Position within the SCL period, 0 to 9 |
| scl_pull_low | output | 1 | 1 drives SCL low, 0 releases it |

## Verification
Several divisor settings are loaded in each convention, each checked strobe by strobe against its expected cycle and slot. Swapping M and N across settings shows whether the fields sit in the right bit positions, and the same M/N under both conventions shows that the exponent switch alters only the power term. The extremes (every cycle, and the 4096-cycle span) test the counter width. A rewrite in the middle of a slot, a low SCL during the driven-low half, and a low SCL in the middle of a count in the released half each tell apart restarting, ignoring and clearing from simply holding the count.

// File: rtl/scl_div_pkg.sv
`timescale 1ns/1ps
package scl_div_pkg;
  localparam int unsigned DIV_M_W = 4;
  localparam int unsigned DIV_N_W = 3;
  localparam int unsigned DIV_W   = DIV_M_W + DIV_N_W;
  // widest span: 2^M_W * 2^(2^N_W) needs M_W + 2^N_W + 1 bits
  localparam int unsigned CNT_W   = DIV_M_W + (1 << DIV_N_W) + 1;

  typedef struct packed {
    logic [DIV_M_W-1:0] m;
    logic [DIV_N_W-1:0] n;
  } div_cfg_t;

  // system clocks per strobe for a divisor and exponent convention
  function automatic logic [CNT_W-1:0] span_of(div_cfg_t d, logic base_zero);
    logic [CNT_W-1:0] lin;
    logic [DIV_N_W:0] sh;
    lin = CNT_W'(d.m) + CNT_W'(1);
    sh  = base_zero ? {1'b0, d.n} : ({1'b0, d.n} + 1'b1);
    return lin << sh;
  endfunction
endpackage

// File: rtl/scl_rst_sync.sv
`timescale 1ns/1ps
module scl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb begin
    sr_d = {sr_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sr_q <= '0;
    else         sr_q <= sr_d;
  end

  assign srst_n = sr_q[STAGES-1];
endmodule

// File: rtl/scl_div_reg.sv
`timescale 1ns/1ps
module scl_div_reg
  import scl_div_pkg::*;
#(
  parameter logic [DIV_W-1:0] RESET_DIV = '0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  div_cfg_t wdata,
  output div_cfg_t cfg
);
  div_cfg_t cfg_q;
  div_cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (load) cfg_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= div_cfg_t'(RESET_DIV);
    else        cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/scl_prescaler.sv
`timescale 1ns/1ps
module scl_prescaler #(
  parameter int unsigned W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] span,
  input  logic         restart,
  input  logic         stall,
  output logic         tick
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         at_end;

  // >= so that a shorter span loaded mid-count ends the slot at once
  assign at_end = (cnt_q >= (span - W'(1)));
  assign tick   = at_end & ~stall;

  always_comb begin
    if (restart || stall || at_end) cnt_d = '0;
    else                            cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/scl_phase_seq.sv
`timescale 1ns/1ps
module scl_phase_seq #(
  parameter int unsigned HALF   = 5,
  parameter int unsigned SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              restart,
  output logic [SLOT_W-1:0] slot,
  output logic              pull_low,
  output logic              hi_phase
);
  localparam logic [SLOT_W-1:0] LAST  = SLOT_W'(2 * HALF - 1);
  localparam logic [SLOT_W-1:0] HALFV = SLOT_W'(HALF);

  logic [SLOT_W-1:0] slot_q;
  logic [SLOT_W-1:0] slot_d;
  logic              pull_q;
  logic              pull_d;

  always_comb begin
    slot_d = slot_q;
    if (restart)     slot_d = '0;
    else if (adv)    slot_d = (slot_q == LAST) ? '0 : slot_q + SLOT_W'(1);
    pull_d = (slot_d < HALFV);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      pull_q <= 1'b1;
    end else begin
      slot_q <= slot_d;
      pull_q <= pull_d;
    end
  end

  assign slot     = slot_q;
  assign pull_low = pull_q;
  assign hi_phase = ~pull_q;
endmodule

// File: rtl/scl_clkgen.sv
`timescale 1ns/1ps
module scl_clkgen
  import scl_div_pkg::*;
#(
  parameter int unsigned       HALF_TICKS = 5,
  parameter logic [DIV_W-1:0]  RESET_DIV  = '0
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   cfg_we,
  input  logic [DIV_W-1:0]                       cfg_div,
  input  logic                                   exp_sel,
  input  logic                                   scl_in,
  output logic                                   tick,
  output logic [$clog2(2*HALF_TICKS)-1:0]        slot,
  output logic                                   scl_pull_low
);
  localparam int unsigned SLOT_W = $clog2(2 * HALF_TICKS);

  logic           srst_n;
  div_cfg_t       cfg;
  logic [CNT_W-1:0] span;
  logic           hi_phase;
  logic           stall;
  logic           tick_w;

  scl_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  scl_div_reg #(.RESET_DIV(RESET_DIV)) u_div (
    .clk   (clk),
    .rst_n (srst_n),
    .load  (cfg_we),
    .wdata (div_cfg_t'(cfg_div)),
    .cfg   (cfg)
  );

  assign span  = span_of(cfg, exp_sel);
  // a target holding SCL low in the released half freezes the timing
  assign stall = hi_phase & ~scl_in;

  scl_prescaler #(.W(CNT_W)) u_pre (
    .clk     (clk),
    .rst_n   (srst_n),
    .span    (span),
    .restart (cfg_we),
    .stall   (stall),
    .tick    (tick_w)
  );

  scl_phase_seq #(.HALF(HALF_TICKS), .SLOT_W(SLOT_W)) u_seq (
    .clk      (clk),
    .rst_n    (srst_n),
    .adv      (tick_w),
    .restart  (cfg_we),
    .slot     (slot),
    .pull_low (scl_pull_low),
    .hi_phase (hi_phase)
  );

  assign tick = tick_w;
endmodule

// File: rtl/scl_clkgen_chk.sv
`timescale 1ns/1ps
module scl_clkgen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_we,
  input logic       scl_in,
  input logic       tick,
  input logic [3:0] slot,
  input logic       scl_pull_low
);
  assert_slot_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    slot <= 4'd9);

  assert_slot_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cfg_we) |=> $stable(slot));

  assert_slot_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cfg_we && slot == 4'd9) |=> (slot == 4'd0));

  assert_pull_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_pull_low) |-> (slot == 4'd0));

  assert_stretch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_pull_low && !scl_in) |-> !tick);

  assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (slot == 4'd0 && scl_pull_low));
endmodule

bind scl_clkgen scl_clkgen_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_we       (cfg_we),
  .scl_in       (scl_in),
  .tick         (tick),
  .slot         (slot),
  .scl_pull_low (scl_pull_low)
);

// File: tb/sim_scl_clkgen.sv
`timescale 1ns/1ps
module sim_scl_clkgen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [6:0] cfg_div = 7'd0;
  logic       exp_sel = 1'b0;
  logic       scl_in = 1'b1;
  logic       tick;
  logic [3:0] slot;
  logic       scl_pull_low;

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    at;
    int    slot;
    string req;
  } exp_t;

  exp_t sb[$];
  exp_t cur;
  int   n_cmp = 0;
  int   n_bad = 0;

  scl_clkgen u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_div      (cfg_div),
    .exp_sel      (exp_sel),
    .scl_in       (scl_in),
    .tick         (tick),
    .slot         (slot),
    .scl_pull_low (scl_pull_low)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic nxt();
    @(posedge clk);
    #2;
  endtask

  // driver: load a divisor and queue the expected strobes
  task automatic do_cfg(input int m, input int n, input bit alt, input int cnt,
                        input string req);
    int w;
    int span;
    @(negedge clk);
    cfg_div = {m[3:0], n[2:0]};
    exp_sel = alt;
    cfg_we  = 1'b1;
    @(posedge clk);
    #1;
    cfg_we = 1'b0;
    w      = cyc;
    span   = (m + 1) << (alt ? n : n + 1);
    for (int j = 0; j < cnt; j++) sb.push_back('{at: w + span - 1 + j * span, slot: j % 10, req: req});
    #1;
  endtask

  task automatic drain();
    for (int k = 0; k < 20000 && sb.size() > 0; k++) nxt();
    nxt();
  endtask

  // monitor: compare strobes with the queue
  always begin
    @(posedge clk);
    #2;
    if (sb.size() > 0) begin
      if (cyc == sb[0].at) begin
        cur = sb.pop_front();
        check(tick == 1'b1, {cur.req, " strobe present"}, int'(tick), 1);
        check(int'(slot) == cur.slot, {cur.req, " slot at strobe"}, int'(slot), cur.slot);
        check(scl_pull_low == (cur.slot < 5), "R4 pull level", int'(scl_pull_low),
              int'(cur.slot < 5));
      end else if (tick) begin
        check(1'b0, {sb[0].req, " early strobe"}, cyc, sb[0].at);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int t1;
    int t2;
    bit seen;
    // R1 reset state
    repeat (3) nxt();
    check(tick == 1'b0, "R1 tick in reset", int'(tick), 0);
    check(slot == 4'd0, "R1 slot in reset", int'(slot), 0);
    check(scl_pull_low == 1'b1, "R1 pull in reset", int'(scl_pull_low), 1);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 default divisor: strobe every 2 cycles
    t1 = -1; t2 = -1;
    for (int k = 0; k < 40 && t2 < 0; k++) begin
      nxt();
      if (tick) begin
        if (t1 < 0) t1 = cyc;
        else        t2 = cyc;
      end
    end
    check((t2 - t1) == 2, "R1 default span", t2 - t1, 2);

    // R2 default convention, several M/N, including slot wrap
    do_cfg(0, 0, 1'b0, 12, "R2");  drain();
    do_cfg(3, 2, 1'b0, 3,  "R2");  drain();
    do_cfg(5, 1, 1'b0, 3,  "R2");  drain();
    do_cfg(1, 5, 1'b0, 2,  "R2");  drain();
    do_cfg(15, 7, 1'b0, 2, "R2");  drain();
    // R3 alternate convention
    do_cfg(3, 2, 1'b1, 3,  "R3");  drain();
    do_cfg(0, 0, 1'b1, 11, "R3");  drain();
    do_cfg(15, 7, 1'b1, 1, "R3");  drain();

    // R6 rewrite mid-period and mid-count
    do_cfg(0, 0, 1'b0, 0, "R6");
    repeat (13) nxt();
    do_cfg(1, 1, 1'b0, 3, "R6");
    check(slot == 4'd0, "R6 slot after write", int'(slot), 0);
    drain();
    do_cfg(3, 2, 1'b0, 0, "R6");
    repeat (20) nxt();
    do_cfg(3, 2, 1'b0, 2, "R6");
    drain();

    // R7 scl_in low in the driven-low half
    @(negedge clk);
    scl_in = 1'b0;
    do_cfg(0, 0, 1'b1, 0, "R7");
    repeat (4) nxt();
    check(slot == 4'd4 && tick, "R7 slot advances while SCL low", int'(slot), 4);
    nxt();
    check(slot == 4'd5 && !tick, "R5 stall at released half", int'(tick), 0);
    scl_in = 1'b1;
    nxt();

    // R5 stretch in the middle of a count, span 4
    do_cfg(1, 0, 1'b0, 0, "R5");
    seen = 1'b0;
    for (int k = 0; k < 200 && !seen; k++) begin
      nxt();
      if (slot == 4'd5) seen = 1'b1;
    end
    check(seen, "R5 reached released half", int'(seen), 1);
    nxt();
    nxt();
    scl_in = 1'b0;
    for (int k = 0; k < 6; k++) begin
      nxt();
      check(!tick && slot == 4'd5, "R5 hold while stretched", int'(slot), 5);
    end
    scl_in = 1'b1;
    nxt();
    check(!tick, "R5 no strobe 1 after release", int'(tick), 0);
    nxt();
    check(!tick, "R5 no strobe 2 after release", int'(tick), 0);
    nxt();
    check(tick && slot == 4'd5, "R5 strobe after cleared count", int'(tick), 1);
    nxt();
    check(slot == 4'd6, "R5 slot resumes", int'(slot), 6);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule